// File: doc/BRIEF.md
# Sensor Interrupt Pin Controller

This block turns two internal event strobes of a motion sensor, a new-sample strobe (data-ready) and a sample-store-full strobe (buffer-full), into the level on one physical interrupt pin. It also keeps a pending-status vector that host logic reads and clears. Each source has a routing bit that connects it to the pin. Data-ready also needs a global enable before it can reach the pin. Buffer-full needs only its routing bit.

The pin has three configuration fields: a master enable, an output polarity and a choice between two signalling styles. In pulse style, every routed event produces a pulse that lasts a parameterized number of clock cycles. The default of 2000 cycles gives 40 us at 50 MHz. An event that arrives while a pulse is still running restarts the count, so overlapping events merge into one longer pulse. In latched style, the pin stays active for as long as any routed source is pending. Configuration arrives as plain inputs that use the register bit positions of the sensor.

Top module: `irq_pin_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, both pending bits are 0 and the pin sits at its inactive level.
- R2: A data-ready strobe affects the pin only when `drdy_en_i` is 1 and `route_i[4]` is 1.
- R3: A buffer-full strobe reaches the pin when `route_i[6]` is 1, whatever the value of `drdy_en_i`.
- R4: `pin_cfg_i` decodes as follows: bit 5 is the pin enable, bit 4 is the polarity (1 = active high, 0 = active low) and bit 3 is the style (1 = pulse, 0 = latched). The value 0x38 therefore selects an enabled, active-high, pulsed pin.
- R5: In pulse style, a routed strobe sampled at clock edge E makes the pin active from E for exactly PULSE_CYCLES cycles.
- R6: A routed strobe that arrives during a pulse reloads the timer. The pin then stays active until PULSE_CYCLES cycles after the last strobe, with no gap in between.
- R7: In latched style, the pin is active while (pending & routed sources) is nonzero, and it returns to inactive once the host clears those bits.
- R8: With the pin disabled, the pin drives the inactive level of the selected polarity, and events produce no pulse.
- R9: `pending_o[0]` (data-ready) and `pending_o[1]` (buffer-full) are set by their strobe whether or not the source is enabled or routed. A 1 in `clr_i` clears the matching bit. If a set and a clear fall in the same cycle, the set wins.
- R10: Bits of `route_i` other than 4 and 6 have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_drdy_i | input | 1 | One-cycle new-sample strobe |
| evt_bfull_i | input | 1 | One-cycle buffer-full strobe |
| drdy_en_i | input | 1 | Global data-ready enable |
| route_i | input | 8 | Pin routing: bit 4 = data-ready, bit 6 = buffer-full |
| pin_cfg_i | input | 8 | Pin control: bit 5 = enable, bit 4 = polarity, bit 3 = pulse style |
| clr_i | input | 2 | Pending clear, one bit per source |
| int_pin_o | output | 1 | Physical interrupt pin level |
| pending_o | output | 2 | Pending status: bit 0 = data-ready, bit 1 = buffer-full |

## Verification
The assertions take the event strobes and clears to be synchronous to `clk`. They also take configuration changes to happen between events and not in the middle of a check window. The pulse-timer checks further assume that a load request only occurs while the pin is enabled in pulse style. The bench changes configuration only at falling edges and holds it stable across each measured pulse. It drives every strobe for exactly one cycle, so each event corresponds to exactly one load or one set.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

    localparam int NUM_SRC         = 2;
    localparam int SRC_DRDY        = 0;
    localparam int SRC_BFULL       = 1;

    localparam int ROUTE_DRDY_BIT  = 4;
    localparam int ROUTE_BFULL_BIT = 6;

    localparam int CFG_EN_BIT      = 5;
    localparam int CFG_POL_BIT     = 4;
    localparam int CFG_PULSE_BIT   = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic {
        STYLE_LATCHED = 1'b0,
        STYLE_PULSE   = 1'b1
    } pin_style_e;

    typedef struct packed {
        logic       enable;
        logic       act_high;
        pin_style_e style;
    } pin_cfg_t;

    function automatic pin_cfg_t decode_pin_cfg(input logic [7:0] raw);
        pin_cfg_t c;
        c.enable   = raw[CFG_EN_BIT];
        c.act_high = raw[CFG_POL_BIT];
        c.style    = pin_style_e'(raw[CFG_PULSE_BIT]);
        return c;
    endfunction

    function automatic src_vec_t routed_mask(input logic drdy_en, input logic [7:0] route);
        src_vec_t m;
        m[SRC_DRDY]  = drdy_en & route[ROUTE_DRDY_BIT];
        m[SRC_BFULL] = route[ROUTE_BFULL_BIT];
        return m;
    endfunction

    function automatic logic pin_level(input logic active, input logic act_high);
        return active ? act_high : ~act_high;
    endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending
    import irq_pin_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar k = 0; k < N; k++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)           q <= 1'b0;
            else if (set_i[k]) q <= 1'b1;
            else if (clr_i[k]) q <= 1'b0;
        end
        assign pend_o[k] = q;

        AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> pend_o[k]);                                   // R9
        AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !pend_o[k]);                   // R9
    end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
    parameter int PULSE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic active_o
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load_i)      cnt <= RELOAD;
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign active_o = (cnt != '0);

    AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt == RELOAD));                                   // R6
    AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (active_o && !load_i) |=> (cnt == $past(cnt) - CW'(1)));       // R5
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= RELOAD);                                                // R5

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
    import irq_pin_pkg::*;
(
    input  pin_cfg_t cfg_i,
    input  logic     pulse_active_i,
    input  logic     latch_active_i,
    output logic     pin_o
);

    logic active;

    always_comb begin
        active = 1'b0;
        if (cfg_i.enable) begin
            unique case (cfg_i.style)
                STYLE_PULSE:   active = pulse_active_i;
                STYLE_LATCHED: active = latch_active_i;
                default:       active = 1'b0;
            endcase
        end
        pin_o = pin_level(active, cfg_i.act_high);
    end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int PULSE_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_drdy_i,
    input  logic       evt_bfull_i,
    input  logic       drdy_en_i,
    input  logic [7:0] route_i,
    input  logic [7:0] pin_cfg_i,
    input  logic [1:0] clr_i,
    output logic       int_pin_o,
    output logic [1:0] pending_o
);

    pin_cfg_t cfg;
    src_vec_t evt, mask, pend;
    logic     fire, latch_active, pulse_active;
    logic     unused_cfg_bits;

    assign cfg  = decode_pin_cfg(pin_cfg_i);
    assign mask = routed_mask(drdy_en_i, route_i);

    always_comb begin
        evt            = '0;
        evt[SRC_DRDY]  = evt_drdy_i;
        evt[SRC_BFULL] = evt_bfull_i;
    end

    assign fire         = (|(evt & mask)) && cfg.enable && (cfg.style == STYLE_PULSE);
    assign latch_active = |(pend & mask);

    assign unused_cfg_bits = ^{route_i[7], route_i[5], route_i[3:0],
                               pin_cfg_i[7:6], pin_cfg_i[2:0]};

    irq_pending #(.N(NUM_SRC)) u_pending (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt),
        .clr_i  (clr_i),
        .pend_o (pend)
    );

    irq_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (fire),
        .active_o (pulse_active)
    );

    irq_pin_driver u_driver (
        .cfg_i          (cfg),
        .pulse_active_i (pulse_active),
        .latch_active_i (latch_active),
        .pin_o          (int_pin_o)
    );

    assign pending_o = pend;

    AST_FIRE_STARTS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (fire && $stable(pin_cfg_i)) ##1 $stable(pin_cfg_i)
            |-> (int_pin_o == pin_cfg_i[CFG_POL_BIT]));                // R5
    AST_NO_UNROUTED_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |-> ((evt_drdy_i && drdy_en_i && route_i[ROUTE_DRDY_BIT])
                  || (evt_bfull_i && route_i[ROUTE_BFULL_BIT])));     // R2

endmodule

// File: tb/tb_irq_pin_ctrl.sv
`timescale 1ns/1ps
module tb_irq_pin_ctrl;

    localparam int PW = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       evt_drdy, evt_bfull, drdy_en;
    logic [7:0] route, cfg;
    logic [1:0] clr;
    logic       pin;
    logic [1:0] pend;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_pin_ctrl #(.PULSE_CYCLES(PW)) dut (
        .clk        (clk),
        .rst        (rst),
        .evt_drdy_i (evt_drdy),
        .evt_bfull_i(evt_bfull),
        .drdy_en_i  (drdy_en),
        .route_i    (route),
        .pin_cfg_i  (cfg),
        .clr_i      (clr),
        .int_pin_o  (pin),
        .pending_o  (pend)
    );

    typedef struct packed {
        logic       den;
        logic [7:0] route;
        logic [7:0] cfg;
        logic       ed;
        logic       eb;
        logic [1:0] clr;
        logic       exp_pin;
        logic [1:0] exp_pend;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 8'h30, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01},
        '{1'b1, 8'h10, 8'h30, 1'b0, 1'b0, 2'b00, 1'b1, 2'b01},
        '{1'b1, 8'h10, 8'h30, 1'b0, 1'b0, 2'b01, 1'b0, 2'b00},
        '{1'b1, 8'h00, 8'h30, 1'b1, 1'b0, 2'b00, 1'b0, 2'b01},
        '{1'b1, 8'h10, 8'h30, 1'b1, 1'b0, 2'b01, 1'b1, 2'b01},
        '{1'b1, 8'h10, 8'h30, 1'b0, 1'b0, 2'b01, 1'b0, 2'b00},
        '{1'b0, 8'h40, 8'h30, 1'b0, 1'b1, 2'b00, 1'b1, 2'b10},
        '{1'b0, 8'h40, 8'h10, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10},
        '{1'b0, 8'h40, 8'h00, 1'b0, 1'b0, 2'b00, 1'b1, 2'b10},
        '{1'b0, 8'h40, 8'h20, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10},
        '{1'b0, 8'h40, 8'h20, 1'b0, 1'b0, 2'b10, 1'b1, 2'b00},
        '{1'b1, 8'hAF, 8'h30, 1'b1, 1'b1, 2'b00, 1'b0, 2'b11},
        '{1'b1, 8'hAF, 8'h30, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00}
    };

    string vtag [NV];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input logic den, input logic [7:0] r, input logic [7:0] c);
        drdy_en = den;
        route   = r;
        cfg     = c;
    endtask

    // Counts consecutive samples at the active level, starting at the current sample.
    task automatic count_active(input logic act, inout int n);
        for (int i = 0; i < 64; i++) begin
            if (pin !== act) break;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        vtag = '{"R2", "R7", "R7", "R2", "R9", "R9", "R3", "R8",
                 "R8", "R4", "R7", "R10", "R9"};
        rst = 1'b1;
        evt_drdy = 1'b0; evt_bfull = 1'b0; clr = 2'b00;
        setup(1'b1, 8'h10, 8'h38);
        evt_drdy = 1'b1;
        repeat (3) @(negedge clk);
        check(pin == 1'b0, "R1 pin in reset", pin, 0);
        check(pend == 2'b00, "R1 pend in reset", pend, 0);
        evt_drdy = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(pin == 1'b0 && pend == 2'b00, "R1 after reset", {pin, pend}, 0);

        // Latched-style table
        for (int v = 0; v < NV; v++) begin
            setup(VECS[v].den, VECS[v].route, VECS[v].cfg);
            evt_drdy  = VECS[v].ed;
            evt_bfull = VECS[v].eb;
            clr       = VECS[v].clr;
            @(negedge clk);
            evt_drdy = 1'b0; evt_bfull = 1'b0; clr = 2'b00;
            check(pin == VECS[v].exp_pin, {vtag[v], " pin"}, pin, VECS[v].exp_pin);
            check(pend == VECS[v].exp_pend, {vtag[v], " pend"}, pend, VECS[v].exp_pend);
        end

        // R5 + R4: 0x38 gives an active-high pulse of PW cycles
        setup(1'b1, 8'h10, 8'h38);
        @(negedge clk);
        check(pin == 1'b0, "R4 idle before pulse", pin, 0);
        evt_drdy = 1'b1;
        @(negedge clk);
        evt_drdy = 1'b0;
        n = 0;
        count_active(1'b1, n);
        check(n == PW, "R5 pulse width", n, PW);

        // R4: active-low pulse with 0x28, buffer-full with data-ready disabled (R3)
        setup(1'b0, 8'h40, 8'h28);
        @(negedge clk);
        check(pin == 1'b1, "R4 active-low idle", pin, 1);
        evt_bfull = 1'b1;
        @(negedge clk);
        evt_bfull = 1'b0;
        n = 0;
        count_active(1'b0, n);
        check(n == PW, "R3 bfull low pulse width", n, PW);

        // R2: data-ready in pulse style without global enable gives no pulse
        setup(1'b0, 8'h10, 8'h38);
        evt_drdy = 1'b1;
        @(negedge clk);
        evt_drdy = 1'b0;
        check(pin == 1'b0, "R2 no pulse without enable", pin, 0);

        // R6: restart during pulse merges into PW+3 active cycles
        setup(1'b1, 8'h10, 8'h38);
        repeat (PW + 2) @(negedge clk);
        evt_drdy = 1'b1;
        @(negedge clk);
        evt_drdy = 1'b0;
        n = (pin == 1'b1) ? 1 : 0;
        @(negedge clk);
        if (pin == 1'b1) n++;
        @(negedge clk);
        if (pin == 1'b1) n++;
        evt_drdy = 1'b1;
        @(negedge clk);
        evt_drdy = 1'b0;
        count_active(1'b1, n);
        check(n == PW + 3, "R6 merged pulse length", n, PW + 3);

        // R8: disabled pin ignores events in pulse style
        setup(1'b1, 8'h10, 8'h18);
        repeat (2) @(negedge clk);
        evt_drdy = 1'b1;
        @(negedge clk);
        evt_drdy = 1'b0;
        n = 0;
        for (int i = 0; i < PW; i++) begin
            if (pin != 1'b0) n++;
            @(negedge clk);
        end
        check(n == 0, "R8 no pulse when disabled", n, 0);
        check(pend[0] == 1'b1, "R9 pend set while disabled", pend[0], 1);

        // R10: unrelated route bits do not start a pulse
        clr = 2'b11;
        setup(1'b1, 8'hAF, 8'h38);
        @(negedge clk);
        clr = 2'b00;
        evt_drdy = 1'b1; evt_bfull = 1'b1;
        @(negedge clk);
        evt_drdy = 1'b0; evt_bfull = 1'b0;
        check(pin == 1'b0, "R10 no pulse via other bits", pin, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule